// File: doc/BRIEF.md
# Coulomb-Counter Conversion Interval Scheduler

This block generates the timing strobes for a coulomb-counting converter clocked from a slow oscillator of about 32.768 kHz. It runs in one of two modes. In accumulate mode it repeats conversions back to back, and each conversion lasts a selectable power-of-two number of converter cycles. In regular-current mode it runs periods made of a selectable idle interval followed by a fixed sampling window of about 12 ms.

Software controls the block through two 2-bit length selects and a write strobe that carries one data bit. A write aborts whatever is in progress. Writing 1 moves the block into regular-current mode and writing 0 returns it to accumulate mode. A select change is picked up only when a new conversion or period starts. A run enable halts the schedule and holds it ready for a fresh start.

Top module: `cc_interval_sched`

## Requirements
- R1: After reset `regMode` is 0 and neither `accDone` nor `sampleDone` is high.
- R2: In accumulate mode a conversion lasts 2^(ACC_BASE_LOG2+accSel) cycles. With the default of 12, codes 0, 1, 2 and 3 give 4096, 8192, 16384 and 32768 cycles.
- R3: `accDone` is high for exactly one cycle, in the last cycle of each conversion. The next conversion starts in the following cycle, so consecutive pulses are exactly one conversion length apart.
- R4: In regular-current mode one period is 2^(REG_BASE_LOG2+regSel) idle cycles followed by SAMPLE_CYC sampling cycles. The defaults are 13 and 393, so codes 0 to 3 give 8192, 16384, 32768 and 65536 idle cycles. `sampleDone` pulses for one cycle in the last cycle of the sampling window.
- R5: A cycle with `ctlWr`=1 and `ctlVal`=1 aborts the ongoing activity. From the next cycle `regMode` is 1, and the first `sampleDone` comes idle+SAMPLE_CYC cycles after the write cycle.
- R6: A cycle with `ctlWr`=1 and `ctlVal`=0 aborts the ongoing activity. From the next cycle `regMode` is 0, and the first `accDone` comes one full conversion length after the write cycle.
- R7: An aborted conversion or period produces no done pulse. This holds even when the write falls in the cycle that would have completed it.
- R8: A change of `accSel` or `regSel` has no effect on the conversion or idle interval in progress. It applies from the next one.
- R9: While `runEn` is 0 no pulse is produced and the schedule is held at its start. If `runEn` rises in cycle R, the first accumulate pulse comes in cycle R+L-1, where L is the conversion length.
- R10: `accDone` appears only while `regMode` is 0 and `sampleDone` only while `regMode` is 1. The two are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rstN | input | 1 | Active-low asynchronous reset |
| runEn | input | 1 | Schedule run enable |
| accSel | input | 2 | Accumulate conversion length code |
| regSel | input | 2 | Regular-current idle interval code |
| ctlWr | input | 1 | Control write strobe (aborts activity) |
| ctlVal | input | 1 | Written mode bit: 1 regular-current, 0 accumulate |
| accDone | output | 1 | One-cycle end-of-conversion pulse |
| sampleDone | output | 1 | One-cycle end-of-sampling-window pulse |
| regMode | output | 1 | 1 while in regular-current mode |

## Verification
A control write and the natural completion of a conversion can fall in the same cycle, and the write must win. The bench provokes this by timing a write to land exactly one conversion length after an observed `accDone`, the cycle where the next pulse was due. It judges the outcome from the time of the next pulse: a suppressed completion puts the next pulse one full length after the write, while a leaked pulse shows up as an early timestamp.

// File: rtl/cc_sched_pkg.sv
package cc_sched_pkg;

  typedef enum logic [1:0] {
    PH_ACC  = 2'd0,
    PH_IDLE = 2'd1,
    PH_SAMP = 2'd2
  } phase_e;

  // Strobes the control FSM hands to the counter datapath.
  typedef struct packed {
    logic   clear;    // zero the counter and latch a new length
    logic   advance;  // count one cycle
    phase_e lenSel;   // which length to latch on clear
  } ctrl_strb_t;

endpackage

// File: rtl/cc_sched_dp.sv
module cc_sched_dp
  import cc_sched_pkg::*;
#(
  parameter int ACC_BASE_LOG2 = 12,
  parameter int REG_BASE_LOG2 = 13,
  parameter int SAMPLE_CYC    = 393,
  parameter int CNT_W         = REG_BASE_LOG2 + 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  ctrl_strb_t strb,
  input  logic [1:0] accSel,
  input  logic [1:0] regSel,
  output logic       atLast
);

  localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);
  localparam logic [CNT_W-1:0] SAMPLAST = CNT_W'(SAMPLE_CYC - 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lastIdx;
  logic [CNT_W-1:0] accLast;
  logic [CNT_W-1:0] idleLast;
  logic [CNT_W-1:0] nextLast;

  always_comb begin
    accLast  = (ONE << (ACC_BASE_LOG2 + int'(accSel))) - ONE;
    idleLast = (ONE << (REG_BASE_LOG2 + int'(regSel))) - ONE;
    unique case (strb.lenSel)
      PH_IDLE: nextLast = idleLast;
      PH_SAMP: nextLast = SAMPLAST;
      default: nextLast = accLast;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt     <= '0;
      lastIdx <= (ONE << ACC_BASE_LOG2) - ONE;
    end else if (strb.clear) begin
      cnt     <= '0;
      lastIdx <= nextLast;
    end else if (strb.advance) begin
      cnt     <= cnt + ONE;
    end
  end

  assign atLast = (cnt == lastIdx);

endmodule

// File: rtl/cc_sched_ctrl.sv
module cc_sched_ctrl
  import cc_sched_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       runEn,
  input  logic       ctlWr,
  input  logic       ctlVal,
  input  logic       atLast,
  output ctrl_strb_t strb,
  output logic       accDone,
  output logic       sampleDone,
  output logic       regMode
);

  phase_e phase, phaseNext;
  logic   modeQ, modeNext;

  always_comb begin
    phaseNext    = phase;
    modeNext     = modeQ;
    strb.clear   = 1'b0;
    strb.advance = 1'b0;
    strb.lenSel  = phase;
    accDone      = 1'b0;
    sampleDone   = 1'b0;
    if (ctlWr) begin
      // abort: restart in the written mode, no pulse for the cut-off run
      modeNext    = ctlVal;
      phaseNext   = ctlVal ? PH_IDLE : PH_ACC;
      strb.clear  = 1'b1;
      strb.lenSel = phaseNext;
    end else if (!runEn) begin
      phaseNext   = modeQ ? PH_IDLE : PH_ACC;
      strb.clear  = 1'b1;
      strb.lenSel = phaseNext;
    end else if (atLast) begin
      strb.clear = 1'b1;
      unique case (phase)
        PH_IDLE: begin
          phaseNext   = PH_SAMP;
          strb.lenSel = PH_SAMP;
        end
        PH_SAMP: begin
          phaseNext   = PH_IDLE;
          strb.lenSel = PH_IDLE;
          sampleDone  = 1'b1;
        end
        default: begin
          phaseNext   = PH_ACC;
          strb.lenSel = PH_ACC;
          accDone     = 1'b1;
        end
      endcase
    end else begin
      strb.advance = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= PH_ACC;
      modeQ <= 1'b0;
    end else begin
      phase <= phaseNext;
      modeQ <= modeNext;
    end
  end

  assign regMode = modeQ;

endmodule

// File: rtl/cc_interval_sched.sv
module cc_interval_sched
  import cc_sched_pkg::*;
#(
  parameter int ACC_BASE_LOG2 = 12,
  parameter int REG_BASE_LOG2 = 13,
  parameter int SAMPLE_CYC    = 393
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       runEn,
  input  logic [1:0] accSel,
  input  logic [1:0] regSel,
  input  logic       ctlWr,
  input  logic       ctlVal,
  output logic       accDone,
  output logic       sampleDone,
  output logic       regMode
);

  localparam int CNT_W = REG_BASE_LOG2 + 4;

  ctrl_strb_t strb;
  logic       atLast;

  cc_sched_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .runEn      (runEn),
    .ctlWr      (ctlWr),
    .ctlVal     (ctlVal),
    .atLast     (atLast),
    .strb       (strb),
    .accDone    (accDone),
    .sampleDone (sampleDone),
    .regMode    (regMode)
  );

  cc_sched_dp #(
    .ACC_BASE_LOG2 (ACC_BASE_LOG2),
    .REG_BASE_LOG2 (REG_BASE_LOG2),
    .SAMPLE_CYC    (SAMPLE_CYC),
    .CNT_W         (CNT_W)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .accSel (accSel),
    .regSel (regSel),
    .atLast (atLast)
  );

endmodule

// File: rtl/cc_interval_sched_chk.sv
module cc_interval_sched_chk (
  input logic clk,
  input logic rstN,
  input logic runEn,
  input logic ctlWr,
  input logic ctlVal,
  input logic accDone,
  input logic sampleDone,
  input logic regMode
);

  a_r10_excl: assert property (@(posedge clk) disable iff (!rstN)
    !(accDone && sampleDone));

  a_r10_acc_mode: assert property (@(posedge clk) disable iff (!rstN)
    accDone |-> !regMode);

  a_r10_samp_mode: assert property (@(posedge clk) disable iff (!rstN)
    sampleDone |-> regMode);

  a_r7_abort_silent: assert property (@(posedge clk) disable iff (!rstN)
    ctlWr |-> (!accDone && !sampleDone));

  a_r5_mode_follows: assert property (@(posedge clk) disable iff (!rstN)
    ctlWr |=> (regMode == $past(ctlVal)));

  a_r6_mode_holds: assert property (@(posedge clk) disable iff (!rstN)
    !ctlWr |=> $stable(regMode));

  a_r9_idle_silent: assert property (@(posedge clk) disable iff (!rstN)
    !runEn |-> (!accDone && !sampleDone));

  a_r3_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    accDone |=> !accDone);

  a_r4_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    sampleDone |=> !sampleDone);

endmodule

bind cc_interval_sched cc_interval_sched_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .runEn      (runEn),
  .ctlWr      (ctlWr),
  .ctlVal     (ctlVal),
  .accDone    (accDone),
  .sampleDone (sampleDone),
  .regMode    (regMode)
);

// File: tb/cc_interval_sched_tb.sv
module cc_interval_sched_tb;

  localparam int ACCB = 6;
  localparam int REGB = 7;
  localparam int SMP  = 13;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic runEn = 1'b0;
  logic [1:0] accSel = 2'd0;
  logic [1:0] regSel = 2'd0;
  logic ctlWr = 1'b0;
  logic ctlVal = 1'b0;
  logic accDone, sampleDone, regMode;

  int nChk = 0, nBad = 0;
  int tick = 0, accN = 0, smpN = 0, lastAcc = 0, lastSmp = 0, accWide = 0;
  logic accPrev = 1'b0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  cc_interval_sched #(
    .ACC_BASE_LOG2 (ACCB),
    .REG_BASE_LOG2 (REGB),
    .SAMPLE_CYC    (SMP)
  ) u_dut (
    .clk(clk), .rstN(rstN), .runEn(runEn), .accSel(accSel), .regSel(regSel),
    .ctlWr(ctlWr), .ctlVal(ctlVal), .accDone(accDone),
    .sampleDone(sampleDone), .regMode(regMode)
  );

  // pulse timestamps, taken mid-cycle
  always @(negedge clk) begin
    tick = tick + 1;
    if (accDone) begin
      accN = accN + 1;
      lastAcc = tick;
      if (accPrev) accWide = accWide + 1;
    end
    if (sampleDone) begin
      smpN = smpN + 1;
      lastSmp = tick;
    end
    accPrev = accDone;
  end

  function automatic int accLen(int s); return 1 << (ACCB + s); endfunction
  function automatic int regPer(int s); return (1 << (REG_B_SHIFT(s))) + SMP; endfunction
  function automatic int REG_B_SHIFT(int s); return REGB + s; endfunction

  task automatic check(string req, int act, int exp);
    nChk++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  // write in cycle "target"; returns write cycle
  task automatic writeAt(int target, bit v, output int w);
    step();
    while (tick + 1 < target) step();
    ctlWr = 1'b1; ctlVal = v; w = tick + 1;
    step();
    ctlWr = 1'b0;
  endtask

  task automatic writeNow(bit v, output int w);
    writeAt(0, v, w);
  endtask

  task automatic waitAcc();
    int t = accN + 1;
    while (accN < t) @(posedge clk);
    #1;
  endtask

  task automatic waitSmp();
    int t = smpN + 1;
    while (smpN < t) @(posedge clk);
    #1;
  endtask

  task automatic testReset();
    @(negedge clk); #1;
    check("R1 regMode", int'(regMode), 0);
    check("R1 accDone", int'(accDone), 0);
    check("R1 sampleDone", int'(sampleDone), 0);
    repeat (150) step();
    check("R9 no pulse while halted", accN + smpN, 0);
  endtask

  task automatic testRunStart();
    int r;
    accSel = 2'd0;
    step();
    runEn = 1'b1; r = tick + 1;
    waitAcc();
    check("R9 first pulse after run", lastAcc, r + accLen(0) - 1);
    runEn = 1'b0;
    begin
      int n0 = accN;
      repeat (3 * accLen(0)) step();
      check("R9 halted no pulse", accN, n0);
    end
    runEn = 1'b1;
  endtask

  task automatic testAccCodes();
    for (int s = 0; s < 4; s++) begin
      int w, p1;
      accSel = 2'(s);
      writeNow(1'b0, w);
      check("R6 regMode cleared", int'(regMode), 0);
      waitAcc();
      check("R6 first acc after write", lastAcc - w, accLen(s));
      p1 = lastAcc;
      waitAcc();
      check("R2 acc interval", lastAcc - p1, accLen(s));
    end
    check("R3 single-cycle pulses", accWide, 0);
  endtask

  task automatic testRegCodes();
    for (int s = 0; s < 4; s++) begin
      int w, p1, a0;
      regSel = 2'(s);
      a0 = accN;
      writeNow(1'b1, w);
      check("R5 regMode set", int'(regMode), 1);
      waitSmp();
      check("R5 first sample after write", lastSmp - w, regPer(s));
      p1 = lastSmp;
      waitSmp();
      check("R4 sample period", lastSmp - p1, regPer(s));
      check("R10 no acc pulse in reg mode", accN, a0);
    end
  endtask

  task automatic testAbortMid();
    int w, p, s0;
    accSel = 2'd0;
    writeNow(1'b0, w);
    waitAcc();
    p = lastAcc;
    writeAt(p + 30, 1'b0, w);
    waitAcc();
    check("R7 mid abort restarts acc", lastAcc, w + accLen(0));
    p = lastAcc;
    s0 = accN;
    regSel = 2'd0;
    writeAt(p + 20, 1'b1, w);
    waitSmp();
    check("R7 abort into reg no acc pulse", accN, s0);
    check("R7 abort into reg sample time", lastSmp - w, regPer(0));
  endtask

  task automatic testCollision();
    int w, p;
    accSel = 2'd1;
    writeNow(1'b0, w);
    waitAcc();
    p = lastAcc;
    writeAt(p + accLen(1), 1'b0, w);
    waitAcc();
    check("R7 write on completion cycle", lastAcc, p + 2 * accLen(1));
  endtask

  task automatic testSelChange();
    int w, p;
    accSel = 2'd1;
    writeNow(1'b0, w);
    repeat (50) step();
    accSel = 2'd0;
    waitAcc();
    check("R8 current conv keeps length", lastAcc - w, accLen(1));
    p = lastAcc;
    waitAcc();
    check("R8 next conv new length", lastAcc - p, accLen(0));
    regSel = 2'd2;
    writeNow(1'b1, w);
    repeat (40) step();
    regSel = 2'd0;
    waitSmp();
    check("R8 current idle keeps length", lastSmp - w, regPer(2));
    p = lastSmp;
    waitSmp();
    check("R8 next period new length", lastSmp - p, regPer(0));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    testReset();
    testRunStart();
    testAccCodes();
    testRegCodes();
    testAbortMid();
    testCollision();
    testSelChange();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nChk++; nBad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

endmodule